// File: doc/BRIEF.md
# Page Transmit Line Sequencer

This block feeds a serial transmitter with the characters of a stored screen while the terminal is sending a whole page. Each load strobe releases at most one byte. The byte is normally the character just read from display memory. The block paces itself against the cursor. In half duplex it advances the cursor on its own. In full duplex it waits until the receiver reports that the byte came back as an echo. Strobes that arrive while it is waiting are dropped.

The block also shapes the lines of the stream. A carriage return found in memory is sent, and a line feed follows it on the next accepted strobe. When a line ends without a carriage return and automatic line wrapping is off, the block sends a carriage return and then a line feed of its own. While it does this, memory reads are held off. When the end of the page is reached in page mode, the scroll request is blocked. A terminate flag is armed instead. That flag ends page mode on the next cycle whose timing code is 7C, unless a cycle whose timing code is 0 comes first and disarms it.

Top module: `pageTxSequencer`

## Requirements
- R1: In half duplex (`halfDuplex`=1), a strobe that accepts a memory character other than 0x0D makes `countUp` pulse high for exactly one cycle, two clock edges after the strobe cycle.
- R2: In full duplex, `countUp` pulses one edge after the first cycle in which `echoDav` is high while the block is waiting for the echo. Any strobe while waiting emits nothing, including a strobe in the same cycle as `echoDav`.
- R3: An accepted memory character 0x0D is sent (`txValid`, `txByte`=0x0D one edge after the strobe). `colClear` pulses in that same cycle, and no `countUp` follows.
- R4: After a 0x0D has been sent, each accepted strobe sends 0x0A in place of the memory byte. The sequence ends only on a strobe where `tcCode`=2 (cycle 1C). Until then, the next strobe sends 0x0A again.
- R5: An accepted non-0x0D character with `eolIn`=1 and `autoCarry`=0 is sent. The next two accepted strobes send 0x0D and then 0x0A. `ramInhibit` stays high from the edge after the end-of-line strobe until the line feed is taken with `tcCode`=2.
- R6: With `autoCarry`=1, `eolIn` has no effect: the next strobe sends the memory character.
- R7: While `pageMode` is high, `scrollOut` stays low. An `eopScroll` pulse arms a terminate flag, and `pageMode` falls on the edge that ends the next cycle with `tcCode`=7.
- R8: A cycle with `tcCode`=0 disarms the terminate flag, so a later `tcCode`=7 leaves `pageMode` high. If `eopScroll` and `tcCode`=0 occur in the same cycle, the flag is armed.
- R9: When `pageMode` is low, `scrollOut` follows `eopScroll` in the same cycle.
- R10: After reset every output is 0, and page mode and the line flags are clear.
- R11: `pageGo` sets `pageMode` on the next edge. Strobes while `pageMode` is low emit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| pageGo | input | 1 | Enter page-transmit mode |
| loadStb | input | 1 | One-cycle load strobe |
| memChar | input | 8 | Character read from display memory |
| eolIn | input | 1 | Cursor sits at end of line |
| eopScroll | input | 1 | Scroll request at end of page |
| halfDuplex | input | 1 | 1 = half duplex, 0 = full duplex |
| autoCarry | input | 1 | Automatic line wrap enabled |
| echoDav | input | 1 | Receiver has the echoed byte |
| tcCode | input | 3 | Encoded timing cycle (0, 2 = 1C, 7 = 7C) |
| txByte | output | 8 | Byte handed to the transmitter |
| txValid | output | 1 | `txByte` is new this cycle |
| countUp | output | 1 | Cursor advance request |
| colClear | output | 1 | Clear the position-within-line counter |
| ramInhibit | output | 1 | Memory loads suppressed |
| pageMode | output | 1 | Page-transmit mode active |
| scrollOut | output | 1 | Scroll request passed on |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an echo and a load strobe: the bench raises `echoDav` and `loadStb` in one cycle while a full-duplex echo is pending. It then expects one `countUp` and no byte. The second pair is the end-of-page request and the timing code that disarms the terminate flag: the bench drives `eopScroll` together with `tcCode`=0 and expects the following 7C cycle to end page mode. A behavioural model compares every output on every clock, so any mishandled collision shows up as a miscompare on the cycle where it happens.

// File: rtl/ptsPkg.sv
package ptsPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic emit;   // register a byte this edge
    logic selCr;  // send carriage return
    logic selLf;  // send line feed
  } txStrobeT;
endpackage

// File: rtl/ptsDatapath.sv
module ptsDatapath
  import ptsPkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CR_CODE = 'h0D,
  parameter logic [DATA_W-1:0] LF_CODE = 'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          stb,
  input  logic [DATA_W-1:0] memChar,
  output logic              isCr,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid
);
  logic [DATA_W-1:0] nextByte;

  assign isCr = (memChar == CR_CODE);

  always_comb begin
    if (stb.selLf)      nextByte = LF_CODE;
    else if (stb.selCr) nextByte = CR_CODE;
    else                nextByte = memChar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte  <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= stb.emit;
      if (stb.emit) txByte <= nextByte;
    end
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.selCr && stb.selLf)); // R5
endmodule

// File: rtl/ptsCtrl.sv
module ptsCtrl
  import ptsPkg::*;
#(
  parameter int TC_W = 3,
  parameter logic [TC_W-1:0] TC_ZERO = 0,
  parameter logic [TC_W-1:0] TC_1C   = 2,
  parameter logic [TC_W-1:0] TC_7C   = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pageGo,
  input  logic            loadStb,
  input  logic            isCr,
  input  logic            eolIn,
  input  logic            eopScroll,
  input  logic            halfDuplex,
  input  logic            autoCarry,
  input  logic            echoDav,
  input  logic [TC_W-1:0] tcCode,
  output txStrobeT        stb,
  output logic            countUp,
  output logic            colClear,
  output logic            ramInhibit,
  output logic            pageMode,
  output logic            scrollOut
);
  logic crFlag, forceFlag, awaitFlag, termFlag;
  logic accept, memPath, advance;

  assign accept  = loadStb && pageMode && !awaitFlag;
  assign memPath = accept && !crFlag && !forceFlag;
  assign advance = awaitFlag && (halfDuplex || echoDav);

  assign stb.emit  = accept;
  assign stb.selLf = crFlag;
  assign stb.selCr = !crFlag && forceFlag;

  assign ramInhibit = crFlag || forceFlag;
  assign scrollOut  = eopScroll && !pageMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crFlag    <= 1'b0;
      forceFlag <= 1'b0;
      awaitFlag <= 1'b0;
      termFlag  <= 1'b0;
      pageMode  <= 1'b0;
      countUp   <= 1'b0;
      colClear  <= 1'b0;
    end else begin
      countUp  <= advance;
      colClear <= memPath && isCr;

      if (accept && crFlag && tcCode == TC_1C)   crFlag <= 1'b0;
      else if (accept && !crFlag && forceFlag)  crFlag <= 1'b1;
      else if (memPath && isCr)                 crFlag <= 1'b1;

      if (accept && !crFlag && forceFlag)                   forceFlag <= 1'b0;
      else if (memPath && !isCr && eolIn && !autoCarry)     forceFlag <= 1'b1;

      if (memPath && !isCr) awaitFlag <= 1'b1;
      else if (advance)     awaitFlag <= 1'b0;

      if (eopScroll && pageMode)  termFlag <= 1'b1;
      else if (tcCode == TC_ZERO) termFlag <= 1'b0;

      if (pageGo)                              pageMode <= 1'b1;
      else if (termFlag && tcCode == TC_7C)    pageMode <= 1'b0;
    end
  end

  AST_HALF_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    awaitFlag && halfDuplex |=> countUp && !awaitFlag); // R1
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    awaitFlag && !halfDuplex && !echoDav |=> awaitFlag && !countUp); // R2
  AST_LF_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    crFlag && accept && tcCode != TC_1C |=> crFlag); // R4
  AST_TERM_END: assert property (@(posedge clk) disable iff (!rstN)
    termFlag && tcCode == TC_7C && !pageGo |=> !pageMode); // R7
endmodule

// File: rtl/pageTxSequencer.sv
module pageTxSequencer
  import ptsPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TC_W   = 3,
  parameter logic [DATA_W-1:0] CR_CODE = 'h0D,
  parameter logic [DATA_W-1:0] LF_CODE = 'h0A,
  parameter logic [TC_W-1:0] TC_ZERO = 0,
  parameter logic [TC_W-1:0] TC_1C   = 2,
  parameter logic [TC_W-1:0] TC_7C   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageGo,
  input  logic              loadStb,
  input  logic [DATA_W-1:0] memChar,
  input  logic              eolIn,
  input  logic              eopScroll,
  input  logic              halfDuplex,
  input  logic              autoCarry,
  input  logic              echoDav,
  input  logic [TC_W-1:0]   tcCode,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid,
  output logic              countUp,
  output logic              colClear,
  output logic              ramInhibit,
  output logic              pageMode,
  output logic              scrollOut
);
  txStrobeT stb;
  logic     isCr;

  ptsCtrl #(.TC_W(TC_W), .TC_ZERO(TC_ZERO), .TC_1C(TC_1C), .TC_7C(TC_7C)) u_ctrl (
    .clk(clk), .rstN(rstN), .pageGo(pageGo), .loadStb(loadStb), .isCr(isCr),
    .eolIn(eolIn), .eopScroll(eopScroll), .halfDuplex(halfDuplex),
    .autoCarry(autoCarry), .echoDav(echoDav), .tcCode(tcCode), .stb(stb),
    .countUp(countUp), .colClear(colClear), .ramInhibit(ramInhibit),
    .pageMode(pageMode), .scrollOut(scrollOut)
  );

  ptsDatapath #(.DATA_W(DATA_W), .CR_CODE(CR_CODE), .LF_CODE(LF_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memChar(memChar), .isCr(isCr),
    .txByte(txByte), .txValid(txValid)
  );

  AST_CR_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txByte == CR_CODE |-> !countUp); // R3
  AST_SCROLL_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    pageMode |-> !scrollOut); // R7
  AST_CLEAR_WITH_CR: assert property (@(posedge clk) disable iff (!rstN)
    colClear |-> txValid && txByte == CR_CODE); // R3
endmodule

// File: tb/tb_pageTxSequencer.sv
module tb_pageTxSequencer;
  logic clk = 0, rstN = 0;
  logic pageGo = 0, loadStb = 0, eolIn = 0, eopScroll = 0;
  logic halfDuplex = 1, autoCarry = 0, echoDav = 0;
  logic [7:0] memChar = 0;
  logic [2:0] tcCode = 3'd5;
  logic [7:0] txByte;
  logic txValid, countUp, colClear, ramInhibit, pageMode, scrollOut;

  int vecs = 0, fails = 0;
  bit done = 0;
  byte seen[$];

  // model state
  bit mCr, mForce, mWait, mTerm, mPage;
  bit eValid, eCu, eClr;
  logic [7:0] eByte;

  pageTxSequencer dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit acc, nPage, nTerm;
    if (!rstN) begin
      {mCr, mForce, mWait, mTerm, mPage, eValid, eCu, eClr} = '0;
      eByte = 0;
    end else begin
      acc = loadStb && mPage && !mWait;
      eCu = mWait && (halfDuplex || echoDav);
      if (eCu) mWait = 0;
      eValid = acc; eClr = 0;
      if (acc) begin
        if (mCr) begin
          eByte = 8'h0A;
          if (tcCode == 3'd2) mCr = 0;
        end else if (mForce) begin
          eByte = 8'h0D; mForce = 0; mCr = 1;
        end else begin
          eByte = memChar;
          if (memChar == 8'h0D) begin mCr = 1; eClr = 1; end
          else begin
            mWait = 1;
            if (eolIn && !autoCarry) mForce = 1;
          end
        end
      end
      nPage = pageGo ? 1'b1 : ((mTerm && tcCode == 3'd7) ? 1'b0 : mPage);
      nTerm = (eopScroll && mPage) ? 1'b1 : ((tcCode == 3'd0) ? 1'b0 : mTerm);
      mPage = nPage; mTerm = nTerm;
    end
    #2;
    chk("R4", "txValid", txValid, eValid);
    chk("R4", "txByte", txByte, eByte);
    chk("R1", "countUp", countUp, eCu);
    chk("R3", "colClear", colClear, eClr);
    chk("R5", "ramInhibit", ramInhibit, mCr || mForce);
    chk("R7", "pageMode", pageMode, mPage);
    chk("R9", "scrollOut", scrollOut, eopScroll && !mPage);
    if (txValid) seen.push_back(txByte);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(logic [7:0] ch, logic eol);
    @(negedge clk); loadStb = 1; memChar = ch; eolIn = eol;
    @(negedge clk); loadStb = 0; eolIn = 0;
  endtask

  task automatic seq(string req, byte exp[$]);
    chk(req, "byte count", seen.size(), exp.size());
    foreach (exp[i]) if (i < seen.size()) chk(req, "sequence byte", seen[i], exp[i]);
    seen.delete();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R10 reset state
    chk("R10", "pageMode at reset", pageMode, 0);
    chk("R10", "txValid at reset", txValid, 0);
    @(negedge clk) rstN = 1;
    // R11 strobes outside page mode are dropped
    strobe("Q", 0); idle(2);
    seq("R11", '{});
    @(negedge clk) pageGo = 1;
    @(negedge clk) pageGo = 0;
    chk("R11", "pageMode after pageGo", pageMode, 1);
    // R1 half duplex advance
    strobe("A", 0); idle(2);
    strobe("B", 0); idle(2);
    seq("R1", '{8'h41, 8'h42});
    // R2 full duplex: strobe while waiting is dropped
    halfDuplex = 0;
    strobe("C", 0); strobe("X", 0); idle(2);
    @(negedge clk) echoDav = 1;
    @(negedge clk) echoDav = 0;
    idle(2);
    seq("R2", '{8'h43});
    // R2 echo and strobe in the same cycle
    strobe("D", 0); idle(1);
    @(negedge clk) begin loadStb = 1; echoDav = 1; memChar = "Y"; end
    @(negedge clk) begin loadStb = 0; echoDav = 0; end
    idle(2);
    seq("R2", '{8'h44});
    halfDuplex = 1;
    // R3 stored carriage return, R4 line feed repeats until cycle 1C
    strobe(8'h0D, 0); idle(1);
    strobe("Z", 0); idle(1);
    chk("R4", "inhibit held without 1C", ramInhibit, 1);
    tcCode = 3'd2; strobe("Z", 0); tcCode = 3'd5; idle(1);
    chk("R4", "inhibit released", ramInhibit, 0);
    strobe("E", 0); idle(2);
    seq("R4", '{8'h0D, 8'h0A, 8'h0A, 8'h45});
    // R5 forced carriage return at end of line
    strobe("F", 1); idle(2);
    chk("R5", "inhibit after eol", ramInhibit, 1);
    strobe("G", 0); idle(1);
    tcCode = 3'd2; strobe("H", 0); tcCode = 3'd5; idle(1);
    strobe("I", 0); idle(2);
    seq("R5", '{8'h46, 8'h0D, 8'h0A, 8'h49});
    // R6 auto carry ignores end of line
    autoCarry = 1;
    strobe("J", 1); idle(2);
    strobe("K", 0); idle(2);
    chk("R6", "no inhibit", ramInhibit, 0);
    autoCarry = 0;
    seq("R6", '{8'h4A, 8'h4B});
    // R8 tc 0 disarms terminate flag
    @(negedge clk) eopScroll = 1;
    @(negedge clk) begin eopScroll = 0; tcCode = 3'd0; end
    @(negedge clk) tcCode = 3'd7;
    @(negedge clk) tcCode = 3'd5;
    idle(1);
    chk("R8", "page survives", pageMode, 1);
    // R8 eop together with tc 0 still arms; R7 then 7C ends page
    @(negedge clk) begin eopScroll = 1; tcCode = 3'd0; end
    @(negedge clk) begin eopScroll = 0; tcCode = 3'd7; end
    @(negedge clk) tcCode = 3'd5;
    chk("R7", "page ended", pageMode, 0);
    // R9 scroll passes when not in page mode
    @(negedge clk) eopScroll = 1;
    #1 chk("R9", "scroll passed", scrollOut, 1);
    @(negedge clk) eopScroll = 0;
    // R11 strobe after page end dropped
    strobe("L", 0); idle(2);
    seq("R11", '{});
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule